// File: doc/BRIEF.md
# Transfer Descriptor Page Segmenter

This block turns the buffer state of a queued transfer descriptor into a sequence of DMA segments, none of which crosses a 4 KiB page boundary. On a start request it captures the page bases of five buffer-pointer words, the current-page index and the byte count to move. It then walks the pages upward from the in-page offset held in the low bits of pointer 0. Each segment is offered as an (address, length) pair under a valid/ready handshake. A zero byte count finishes at once with no segment. A page index that runs past the last usable pointer while bytes remain ends the walk with a processing-error flag.

An isochronous mode reuses the same walker but confines it to two pages. A transaction that fits in the first page gives one segment. One that spills over gives a head piece up to the page end and a tail piece starting at the base of the second pointer.

A separate completion path takes the byte count that was actually moved. It returns the descriptor's new page index, new in-page offset and inverted data toggle, one cycle later. The completion path runs independently of the walker and may be used in any cycle.

Top module: `td_page_segmenter`

## Requirements
- R1: After reset, segValid, done, procErr, busy and updValid are all low.
- R2: Every segment address is bits 31:12 of the selected buffer pointer joined with the current 12-bit in-page offset. The first segment uses pointer[curPage] (pointer[0] in isochronous mode) and offset = bufPtrs[0][11:0]. Every segment length is min(bytes remaining, 4096 - offset).
- R3: When a segment ends exactly at a page end, the next segment starts at offset 0 of the next higher pointer. Segments come in ascending pointer order, and their lengths add up to totalBytes.
- R4: A segment is held with unchanged address and length while segReady is low. With segReady held high, one segment is taken per clock.
- R5: A start with totalBytes = 0 emits no segment and raises done for one cycle, on the clock after the start.
- R6: If the page index exceeds 4 while bytes remain (including a start with curPage above 4), no further segment is offered. Done and procErr rise together for one cycle.
- R7: In isochronous mode (isoMode = 1), offset + length <= 4096 gives the single segment (ptr0 base + offset, length). Otherwise it gives (ptr0 base + offset, 4096 - offset) then (ptr1 base, the rest). Bytes left beyond pointer 1 raise procErr.
- R8: A completion with a positive count C sets s = offset + C, where offset is bufPtrs[0][11:0]. It then reports updPage = (curPage + (s >> 12)) mod 8 and updOffset = s & 0xFFF, with updValid high on the cycle after cmplValid.
- R9: Every completion reports updToggle = !cmplToggle. A count of zero leaves updPage equal to curPage and updOffset equal to bufPtrs[0][11:0].
- R10: A start request while busy is ignored. The running walk continues with the values captured at its own start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startValid | input | 1 | Start a walk (taken only when idle) |
| isoMode | input | 1 | 1 = isochronous two-page split |
| bufPtrs | input | 5x32 | Buffer pointer words; [0][11:0] is the offset |
| curPage | input | 3 | Current page index of the descriptor |
| totalBytes | input | 15 | Bytes to cover with segments |
| segReady | input | 1 | Consumer accepts the offered segment |
| segValid | output | 1 | A segment is offered |
| segAddr | output | 32 | Segment start address |
| segLen | output | 13 | Segment length in bytes (1 to 4096) |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle end-of-walk pulse |
| procErr | output | 1 | Walk ended on an out-of-range page |
| cmplValid | input | 1 | Completion report |
| cmplCount | input | 15 | Bytes actually transferred |
| cmplToggle | input | 1 | Data toggle before completion |
| updValid | output | 1 | Updated descriptor fields valid |
| updPage | output | 3 | New page index |
| updOffset | output | 12 | New in-page offset |
| updToggle | output | 1 | Inverted data toggle |

## Verification
The segment handshake and the completion update can fall in the same cycle, because the walker and the completion registers share inputs but no state. The bench raises cmplValid in the middle of a walk, in a cycle where a segment is also being accepted. It then checks the update fields against their arithmetic and checks that the segment list still matches the model entry by entry. A second overlap tests a fresh start during a walk against the walk's captured values: the new request must leave the list unchanged.

// File: rtl/td_seg_pkg.sv
package td_seg_pkg;

  typedef struct packed {
    logic load;     // capture descriptor state
    logic advance;  // consume the current segment
    logic commit;   // register completion update
  } seg_strobe_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WALK = 2'd1,
    ST_FIN  = 2'd2,
    ST_FAIL = 2'd3
  } seg_state_t;

endpackage

// File: rtl/td_seg_datapath.sv
module td_seg_datapath
  import td_seg_pkg::*;
#(
  parameter int NUM_PTR   = 5,
  parameter int ADDR_W    = 32,
  parameter int PAGE_BITS = 12,
  parameter int BYTES_W   = 15,
  parameter int CPAGE_W   = 3
) (
  input  logic                                clk,
  input  logic                                rstN,
  input  seg_strobe_t                         strobe,
  input  logic                                isoMode,
  input  logic [NUM_PTR-1:0][ADDR_W-1:0]      bufPtrs,
  input  logic [CPAGE_W-1:0]                  curPage,
  input  logic [BYTES_W-1:0]                  totalBytes,
  input  logic [BYTES_W-1:0]                  cmplCount,
  input  logic                                cmplToggle,
  output logic [ADDR_W-1:0]                   segAddr,
  output logic [PAGE_BITS:0]                  segLen,
  output logic                                lastSeg,
  output logic                                pageOver,
  output logic                                zeroStart,
  output logic                                updValid,
  output logic [CPAGE_W-1:0]                  updPage,
  output logic [PAGE_BITS-1:0]                updOffset,
  output logic                                updToggle
);

  localparam int BASE_W    = ADDR_W - PAGE_BITS;
  localparam int LEN_W     = PAGE_BITS + 1;
  localparam int PIDX_W    = CPAGE_W + 1;
  localparam int PAGE_SIZE = 1 << PAGE_BITS;
  localparam int SUM_W     = BYTES_W + 1;

  logic [BASE_W-1:0]    baseQ [NUM_PTR];
  logic [PIDX_W-1:0]    pageIdxQ;
  logic [PIDX_W-1:0]    limitQ;
  logic [PAGE_BITS-1:0] offsetQ;
  logic [BYTES_W-1:0]   remQ;

  logic [LEN_W-1:0]     room;
  logic [BASE_W-1:0]    selBase;

  // Page bases captured at start so the walk is immune to input changes.
  for (genvar g = 0; g < NUM_PTR; g++) begin : g_base
    always_ff @(posedge clk) begin
      if (!rstN)            baseQ[g] <= '0;
      else if (strobe.load) baseQ[g] <= bufPtrs[g][ADDR_W-1:PAGE_BITS];
    end
  end

  always_comb begin
    selBase = '0;
    for (int i = 0; i < NUM_PTR; i++) begin
      if (pageIdxQ == PIDX_W'(i)) selBase = baseQ[i];
    end
  end

  assign room      = LEN_W'(PAGE_SIZE) - {1'b0, offsetQ};
  assign lastSeg   = (BYTES_W'(room) >= remQ);
  assign segLen    = lastSeg ? remQ[LEN_W-1:0] : room;
  assign segAddr   = {selBase, offsetQ};
  assign pageOver  = (pageIdxQ > limitQ);
  assign zeroStart = (totalBytes == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pageIdxQ <= '0;
      limitQ   <= '0;
      offsetQ  <= '0;
      remQ     <= '0;
    end else if (strobe.load) begin
      pageIdxQ <= isoMode ? '0 : PIDX_W'(curPage);
      limitQ   <= isoMode ? PIDX_W'(1) : PIDX_W'(NUM_PTR - 1);
      offsetQ  <= bufPtrs[0][PAGE_BITS-1:0];
      remQ     <= totalBytes;
    end else if (strobe.advance) begin
      remQ <= remQ - BYTES_W'(segLen);
      if (segLen == room) begin
        offsetQ  <= '0;
        pageIdxQ <= pageIdxQ + 1'b1;
      end else begin
        offsetQ  <= offsetQ + segLen[PAGE_BITS-1:0];
      end
    end
  end

  // Completion: fold the moved byte count into page index and offset.
  logic [SUM_W-1:0]     cmplSum;
  logic [CPAGE_W-1:0]   cmplPage;
  assign cmplSum  = SUM_W'(bufPtrs[0][PAGE_BITS-1:0]) + SUM_W'(cmplCount);
  assign cmplPage = curPage + CPAGE_W'(cmplSum >> PAGE_BITS);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      updValid  <= 1'b0;
      updPage   <= '0;
      updOffset <= '0;
      updToggle <= 1'b0;
    end else begin
      updValid <= strobe.commit;
      if (strobe.commit) begin
        updToggle <= ~cmplToggle;
        if (cmplCount != '0) begin
          updPage   <= cmplPage;
          updOffset <= cmplSum[PAGE_BITS-1:0];
        end else begin
          updPage   <= curPage;
          updOffset <= bufPtrs[0][PAGE_BITS-1:0];
        end
      end
    end
  end

  // R8: a completion always produces an update on the next cycle
  a_r8_upd_follows: assert property (@(posedge clk) disable iff (!rstN)
    strobe.commit |=> updValid);

  // R3: consuming a segment never leaves the remaining count growing
  a_r3_rem_shrinks: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.advance && !strobe.load) |=> (remQ < $past(remQ)));

endmodule

// File: rtl/td_seg_control.sv
module td_seg_control
  import td_seg_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        startValid,
  input  logic        segReady,
  input  logic        cmplValid,
  input  logic        zeroStart,
  input  logic        pageOver,
  input  logic        lastSeg,
  output seg_strobe_t strobe,
  output logic        segValid,
  output logic        busy,
  output logic        done,
  output logic        procErr
);

  seg_state_t stateQ, stateD;

  always_comb begin
    stateD         = stateQ;
    strobe         = '0;
    strobe.commit  = cmplValid;
    segValid       = 1'b0;
    unique case (stateQ)
      ST_IDLE: begin
        if (startValid) begin
          strobe.load = 1'b1;
          stateD      = zeroStart ? ST_FIN : ST_WALK;
        end
      end
      ST_WALK: begin
        if (pageOver) begin
          stateD = ST_FAIL;
        end else begin
          segValid = 1'b1;
          if (segReady) begin
            strobe.advance = 1'b1;
            if (lastSeg) stateD = ST_FIN;
          end
        end
      end
      ST_FIN:  stateD = ST_IDLE;
      ST_FAIL: stateD = ST_IDLE;
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  assign busy    = (stateQ != ST_IDLE);
  assign done    = (stateQ == ST_FIN) || (stateQ == ST_FAIL);
  assign procErr = (stateQ == ST_FAIL);

  // R5: end-of-walk pulse and an offered segment never coincide
  a_r5_done_excl: assert property (@(posedge clk) disable iff (!rstN)
    !(segValid && done));

  // R6: an error is only ever flagged on the end-of-walk cycle
  a_r6_err_is_done: assert property (@(posedge clk) disable iff (!rstN)
    procErr |-> done);

  // R5: done lasts a single cycle
  a_r5_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R10: a start while busy does not reload the walker
  a_r10_no_reload: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !strobe.load);

endmodule

// File: rtl/td_page_segmenter.sv
module td_page_segmenter
  import td_seg_pkg::*;
#(
  parameter int NUM_PTR   = 5,
  parameter int ADDR_W    = 32,
  parameter int PAGE_BITS = 12,
  parameter int BYTES_W   = 15,
  parameter int CPAGE_W   = 3
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           startValid,
  input  logic                           isoMode,
  input  logic [NUM_PTR-1:0][ADDR_W-1:0] bufPtrs,
  input  logic [CPAGE_W-1:0]             curPage,
  input  logic [BYTES_W-1:0]             totalBytes,
  input  logic                           segReady,
  output logic                           segValid,
  output logic [ADDR_W-1:0]              segAddr,
  output logic [PAGE_BITS:0]             segLen,
  output logic                           busy,
  output logic                           done,
  output logic                           procErr,
  input  logic                           cmplValid,
  input  logic [BYTES_W-1:0]             cmplCount,
  input  logic                           cmplToggle,
  output logic                           updValid,
  output logic [CPAGE_W-1:0]             updPage,
  output logic [PAGE_BITS-1:0]           updOffset,
  output logic                           updToggle
);

  localparam int PAGE_SIZE = 1 << PAGE_BITS;

  seg_strobe_t strobe;
  logic        lastSeg;
  logic        pageOver;
  logic        zeroStart;

  td_seg_control u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .startValid (startValid),
    .segReady   (segReady),
    .cmplValid  (cmplValid),
    .zeroStart  (zeroStart),
    .pageOver   (pageOver),
    .lastSeg    (lastSeg),
    .strobe     (strobe),
    .segValid   (segValid),
    .busy       (busy),
    .done       (done),
    .procErr    (procErr)
  );

  td_seg_datapath #(
    .NUM_PTR   (NUM_PTR),
    .ADDR_W    (ADDR_W),
    .PAGE_BITS (PAGE_BITS),
    .BYTES_W   (BYTES_W),
    .CPAGE_W   (CPAGE_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .isoMode    (isoMode),
    .bufPtrs    (bufPtrs),
    .curPage    (curPage),
    .totalBytes (totalBytes),
    .cmplCount  (cmplCount),
    .cmplToggle (cmplToggle),
    .segAddr    (segAddr),
    .segLen     (segLen),
    .lastSeg    (lastSeg),
    .pageOver   (pageOver),
    .zeroStart  (zeroStart),
    .updValid   (updValid),
    .updPage    (updPage),
    .updOffset  (updOffset),
    .updToggle  (updToggle)
  );

  // R2: an offered segment is non-empty and stays inside its page
  a_r2_in_page: assert property (@(posedge clk) disable iff (!rstN)
    segValid |-> (segLen != '0) &&
                 (({1'b0, segAddr[PAGE_BITS-1:0]} + segLen) <= (PAGE_BITS+1)'(PAGE_SIZE)));

  // R4: a stalled segment is held unchanged
  a_r4_hold_stable: assert property (@(posedge clk) disable iff (!rstN)
    (segValid && !segReady) |=> segValid && $stable(segAddr) && $stable(segLen));

endmodule

// File: tb/td_page_segmenter_tb.sv
`timescale 1ns/1ps
module td_page_segmenter_tb;

  logic              clk = 1'b0;
  logic              rstN;
  logic              startValid;
  logic              isoMode;
  logic [4:0][31:0]  bufPtrs;
  logic [2:0]        curPage;
  logic [14:0]       totalBytes;
  logic              segReady;
  logic              segValid;
  logic [31:0]       segAddr;
  logic [12:0]       segLen;
  logic              busy, done, procErr;
  logic              cmplValid;
  logic [14:0]       cmplCount;
  logic              cmplToggle;
  logic              updValid;
  logic [2:0]        updPage;
  logic [11:0]       updOffset;
  logic              updToggle;

  always #4 clk = ~clk;

  td_page_segmenter u_dut (
    .clk(clk), .rstN(rstN), .startValid(startValid), .isoMode(isoMode),
    .bufPtrs(bufPtrs), .curPage(curPage), .totalBytes(totalBytes),
    .segReady(segReady), .segValid(segValid), .segAddr(segAddr),
    .segLen(segLen), .busy(busy), .done(done), .procErr(procErr),
    .cmplValid(cmplValid), .cmplCount(cmplCount), .cmplToggle(cmplToggle),
    .updValid(updValid), .updPage(updPage), .updOffset(updOffset),
    .updToggle(updToggle)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  int expAddr [16];
  int expLen  [16];
  int expN;
  bit expErr;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Reference walk computed from the requirements
  task automatic model(input bit iso, input int cp, input int tbytes);
    int pg, lim, off, rem, room, len;
    expN = 0; expErr = 0;
    pg  = iso ? 0 : cp;
    lim = iso ? 1 : 4;
    off = int'(bufPtrs[0][11:0]);
    rem = tbytes;
    while (rem > 0) begin
      if (pg > lim) begin expErr = 1; break; end
      room = 4096 - off;
      len  = (rem < room) ? rem : room;
      expAddr[expN] = int'({bufPtrs[pg][31:12], 12'h000}) | off;
      expLen[expN]  = len;
      expN++;
      rem -= len;
      if (len == room) begin off = 0; pg++; end
      else off += len;
    end
  endtask

  // Run one walk; optionally overlap a stray start (R10) and a completion
  task automatic runWalk(input bit iso, input int cp, input int tbytes,
                         input int readyPct, input bit stray, input bit overlap,
                         input string req);
    int got, cyc, sum, cCnt, cOff, cPg;
    bit cTog, cPend, fin;
    model(iso, cp, tbytes);
    @(negedge clk);
    isoMode = iso; curPage = 3'(cp); totalBytes = 15'(tbytes);
    startValid = 1'b1;
    @(negedge clk);
    startValid = 1'b0;
    got = 0; sum = 0; cyc = 0; cPend = 0; fin = 0;
    while (!fin && cyc < 200) begin
      if (cPend) begin
        cmplValid = 1'b0;
        chk(updValid == 1'b1, "R8 overlap updValid", updValid, 1);
        chk(updPage == 3'(cPg), "R8 overlap updPage", updPage, cPg & 7);
        chk(updOffset == 12'(cOff), "R8 overlap updOffset", updOffset, cOff);
        chk(updToggle == !cTog, "R9 overlap updToggle", updToggle, !cTog);
        cPend = 0;
      end
      startValid = 1'b0;
      if (done) begin
        chk(procErr == expErr, {req, " procErr"}, procErr, expErr);
        chk(got == expN, {req, " segment count"}, got, expN);
        if (!expErr) chk(sum == tbytes, "R3 length sum", sum, tbytes);
        fin = 1;
      end else begin
        if (cyc == 1) chk(busy == 1'b1, "R10 busy during walk", busy, 1);
        if (stray && cyc == 2) begin
          startValid = 1'b1;
          totalBytes = 15'd7;
        end
        segReady = (($urandom % 100) < readyPct);
        if (overlap && cyc == 2) begin
          segReady = 1'b1;
          cCnt = int'($urandom % 9000);
          cTog = 1'($urandom);
          cOff = (int'(bufPtrs[0][11:0]) + cCnt);
          cPg  = (cCnt == 0) ? int'(curPage) : (int'(curPage) + (cOff >> 12)) & 7;
          cOff = cOff & 12'hFFF;
          cmplCount = 15'(cCnt); cmplToggle = cTog; cmplValid = 1'b1;
          cPend = 1;
        end
        if (segValid && segReady) begin
          if (got < expN) begin
            chk(segAddr == 32'(expAddr[got]), {req, " segAddr"}, segAddr, expAddr[got]);
            chk(segLen == 13'(expLen[got]), {req, " segLen"}, segLen, expLen[got]);
          end else begin
            chk(1'b0, {req, " extra segment"}, got + 1, expN);
          end
          sum += int'(segLen);
          got++;
        end
      end
      @(negedge clk);
      cyc++;
    end
    segReady = 1'b0;
    if (!fin) chk(1'b0, {req, " walk timeout"}, cyc, 0);
  endtask

  task automatic runCmpl(input int cnt, input bit tog);
    int s, pg, off;
    @(negedge clk);
    cmplCount = 15'(cnt); cmplToggle = tog; cmplValid = 1'b1;
    s = int'(bufPtrs[0][11:0]) + cnt;
    if (cnt > 0) begin pg = (int'(curPage) + (s >> 12)) & 7; off = s & 12'hFFF; end
    else begin pg = int'(curPage); off = int'(bufPtrs[0][11:0]); end
    @(negedge clk);
    cmplValid = 1'b0;
    chk(updValid == 1'b1, "R8 updValid", updValid, 1);
    chk(updPage == 3'(pg), cnt > 0 ? "R8 updPage" : "R9 zero-count page", updPage, pg);
    chk(updOffset == 12'(off), cnt > 0 ? "R8 updOffset" : "R9 zero-count offset", updOffset, off);
    chk(updToggle == !tog, "R9 toggle inverted", updToggle, !tog);
    @(negedge clk);
    chk(updValid == 1'b0, "R8 updValid single cycle", updValid, 0);
  endtask

  task automatic setPtrs(input int off);
    for (int i = 0; i < 5; i++) bufPtrs[i] = {$urandom, 12'h000} >> 0;
    for (int i = 0; i < 5; i++) bufPtrs[i][11:0] = 12'($urandom);
    bufPtrs[0][11:0] = 12'(off);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=expired expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EC7_0A11));
    rstN = 1'b0; startValid = 1'b0; isoMode = 1'b0; bufPtrs = '0;
    curPage = '0; totalBytes = '0; segReady = 1'b0;
    cmplValid = 1'b0; cmplCount = '0; cmplToggle = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!segValid && !done && !procErr && !busy && !updValid, "R1 reset outputs",
        {segValid, done, procErr, busy, updValid}, 0);
    rstN = 1'b1;

    // Directed corner cases
    setPtrs(0);    runWalk(0, 0, 4096, 100, 0, 0, "R2 exact page");
    setPtrs(4095); runWalk(0, 1, 2, 100, 0, 0, "R3 cross at last byte");
    setPtrs(0);    runWalk(0, 0, 20480, 100, 0, 0, "R3 five full pages");
    setPtrs(1);    runWalk(0, 0, 20480, 100, 0, 0, "R6 spill past pointer 4");
    setPtrs(10);   runWalk(0, 5, 100, 100, 0, 0, "R6 start beyond range");
    setPtrs(10);   runWalk(0, 2, 0, 100, 0, 0, "R5 zero bytes");
    setPtrs(4000); runWalk(1, 3, 200, 100, 0, 0, "R7 iso split");
    setPtrs(100);  runWalk(1, 2, 900, 100, 0, 0, "R7 iso single");
    setPtrs(2048); runWalk(1, 0, 9000, 100, 0, 0, "R7 iso overflow");
    setPtrs(300);  runWalk(0, 1, 9000, 30, 0, 0, "R4 stalled walk");
    setPtrs(500);  runWalk(0, 0, 12000, 60, 1, 0, "R10 stray start");
    setPtrs(700);  runWalk(0, 1, 10000, 100, 0, 1, "R8 overlap walk");
    runCmpl(0, 1'b1);
    runCmpl(4096, 1'b0);
    curPage = 3'd7; setPtrs(4095); runCmpl(1, 1'b1);

    // Random mix
    for (int n = 0; n < 150; n++) begin
      bit iso;
      int cp, tb;
      iso = (($urandom % 4) == 0);
      cp  = int'($urandom % 7);
      tb  = iso ? int'($urandom % 5000) : int'($urandom % 20481);
      if (($urandom % 10) == 0) tb = 0;
      setPtrs(int'($urandom % 4096));
      runWalk(iso, cp, tb, 20 + int'($urandom % 81), (n % 5) == 1, (n % 7) == 3,
              iso ? "R7 random iso" : "R2 random walk");
      curPage = 3'($urandom);
      runCmpl(int'($urandom % 20481), 1'($urandom));
    end

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule